// File: doc/BRIEF.md
# Serial ADC Conversion Reader

This block fetches one result from an external 8-bit converter that delivers its output serially over three wires: an active-low select, a clock driven by this block, and a data line coming back from the converter. A one-cycle start request starts a read. The block pulls select low and produces a slow serial clock from the system clock. It stretches every high and every low phase so that the converter's clock limit is respected. The first serial clock cycle carries no data. After it come eight data cycles, with one bit taken after each falling edge.

Bits arrive most significant first. Each new bit enters at the bottom of a shift register and the bits already held move up by one place. Once the last bit is in, select goes high again and the byte appears on the result output together with a one-cycle done strobe. The result stays on the output until the next read finishes. A start request that arrives while a read is running is ignored.

Top module: `adc_serial_reader`

## Requirements
- R1: After reset, and between reads, `cs_n_o` is 1, `sclk_o` is 0 and `done_o` is 0. Reset also clears `data_o` to zero.
- R2: A `start_i` sampled high while idle drives `cs_n_o` low at that same clock edge, and `sclk_o` is still 0 at that point.
- R3: Every high phase and every low phase of `sclk_o` lasts exactly `HALF_CYC` system cycles. The first rising edge comes `HALF_CYC` cycles after `cs_n_o` falls.
- R4: A read produces exactly `LEAD_CYC + DATA_W` rising edges of `sclk_o`, which is 9 with the defaults. The first `LEAD_CYC` of these cycles take no data.
- R5: A data bit is taken from `sdata_i` exactly one system cycle after each data falling edge of `sclk_o`. The value of `sdata_i` at any other time has no effect on the result.
- R6: The first bit taken lands in `data_o[DATA_W-1]` and the last bit taken lands in `data_o[0]`, because each bit enters at bit 0 as the earlier bits shift left.
- R7: `cs_n_o` returns high one cycle after the last data falling edge. `cs_n_o` is therefore low for exactly `2*(LEAD_CYC+DATA_W)*HALF_CYC + 1` cycles, which is 73 with the defaults.
- R8: `done_o` goes high for exactly one cycle, at the same edge where `cs_n_o` rises. At that point `data_o` holds the new byte, and it keeps that value until the next `done_o`.
- R9: A `start_i` that is high while a read is running has no effect. The timing of that read does not change and only one `done_o` results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Read request, taken only while idle |
| sdata_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Active-low converter select |
| sclk_o | output | 1 | Serial clock to the converter |
| data_o | output | DATA_W | Last assembled byte |
| done_o | output | 1 | One-cycle strobe marking a new byte |

## Verification
The hardest condition to produce from the ports is proving that the sample instant falls exactly one cycle after each data falling edge, and not on the edge itself or anywhere else in the bit period. To reach it, the bench's converter model drives the correct bit only during that single cycle and toggles the data line on every other cycle. Any shift of the sample point therefore corrupts the byte.

The bench sweeps all 256 byte values. In some reads `start_i` is held high for the whole read to show that a restart is refused. After each read the bench counts the rising edges, the cycles with select low and the cycles with the clock high.

// File: rtl/adcr_pkg.sv
package adcr_pkg;

  typedef enum logic {
    RD_IDLE = 1'b0,
    RD_RUN  = 1'b1
  } rd_state_e;

  function automatic int cnt_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/adcr_tick.sv
module adcr_tick #(
  parameter int HALF_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = adcr_pkg::cnt_width(HALF_CYC);
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign tick = run && (cnt == LAST);

endmodule

// File: rtl/adcr_seq.sv
module adcr_seq
  import adcr_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int LEAD_CYC = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic tick,
  output logic run,
  output logic cs_n,
  output logic sclk,
  output logic sample,
  output logic last
);
  localparam int TOTAL_EDGES = 2 * (LEAD_CYC + DATA_W);
  localparam int EW          = cnt_width(TOTAL_EDGES + 1);
  localparam logic [EW-1:0] EDGE_END  = EW'(TOTAL_EDGES);
  localparam logic [EW-1:0] LEAD_EDGE = EW'(2 * LEAD_CYC);

  rd_state_e     state;
  logic [EW-1:0] ecnt;
  logic [EW-1:0] ecnt_nx;
  logic          toggle;
  logic          data_fall;

  assign ecnt_nx   = ecnt + 1'b1;
  assign toggle    = (state == RD_RUN) && tick && (ecnt != EDGE_END);
  assign data_fall = toggle && sclk && (ecnt_nx > LEAD_EDGE);
  assign run       = (state == RD_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= RD_IDLE;
      cs_n   <= 1'b1;
      sclk   <= 1'b0;
      ecnt   <= '0;
      sample <= 1'b0;
      last   <= 1'b0;
    end else begin
      sample <= data_fall;
      last   <= data_fall && (ecnt_nx == EDGE_END);
      unique case (state)
        RD_IDLE: begin
          if (start) begin
            state <= RD_RUN;
            cs_n  <= 1'b0;
            sclk  <= 1'b0;
            ecnt  <= '0;
          end
        end
        RD_RUN: begin
          if (toggle) begin
            sclk <= ~sclk;
            ecnt <= ecnt_nx;
          end
          if (sample && last) begin
            state <= RD_IDLE;
            cs_n  <= 1'b1;
          end
        end
        default: state <= RD_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/adcr_shift.sv
module adcr_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sample,
  input  logic              last,
  input  logic              sdata,
  output logic [DATA_W-1:0] data,
  output logic              done
);
  logic [DATA_W-1:0] sh;
  logic [DATA_W-1:0] sh_nx;

  assign sh_nx = {sh[DATA_W-2:0], sdata};

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '0;
      data <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (sample) begin
        sh <= sh_nx;
        if (last) begin
          data <= sh_nx;
          done <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/adc_serial_reader.sv
module adc_serial_reader #(
  parameter int DATA_W   = 8,
  parameter int HALF_CYC = 4,
  parameter int LEAD_CYC = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              sdata_i,
  output logic              cs_n_o,
  output logic              sclk_o,
  output logic [DATA_W-1:0] data_o,
  output logic              done_o
);
  logic run;
  logic tick;
  logic sample;
  logic last;

  adcr_tick #(.HALF_CYC(HALF_CYC)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .tick (tick)
  );

  adcr_seq #(.DATA_W(DATA_W), .LEAD_CYC(LEAD_CYC)) u_seq (
    .clk    (clk),
    .rst    (rst),
    .start  (start_i),
    .tick   (tick),
    .run    (run),
    .cs_n   (cs_n_o),
    .sclk   (sclk_o),
    .sample (sample),
    .last   (last)
  );

  adcr_shift #(.DATA_W(DATA_W)) u_shift (
    .clk    (clk),
    .rst    (rst),
    .sample (sample),
    .last   (last),
    .sdata  (sdata_i),
    .data   (data_o),
    .done   (done_o)
  );

endmodule

// File: rtl/adcr_checker.sv
module adcr_checker #(
  parameter int DATA_W   = 8,
  parameter int HALF_CYC = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic              cs_n_o,
  input logic              sclk_o,
  input logic [DATA_W-1:0] data_o,
  input logic              done_o
);
  int hi_cnt;

  always_ff @(posedge clk) begin
    if (rst) hi_cnt <= 0;
    else     hi_cnt <= sclk_o ? hi_cnt + 1 : 0;
  end

  // R1: the clock is held low whenever select is high
  a_r1_idle_levels: assert property (@(posedge clk) disable iff (rst)
    cs_n_o |-> !sclk_o);

  // R2: select falls only in response to a start request
  a_r2_cs_from_start: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n_o) |-> $past(start_i) && !sclk_o);

  // R3: every high phase of the clock lasts HALF_CYC cycles
  a_r3_high_len: assert property (@(posedge clk) disable iff (rst)
    $fell(sclk_o) |-> hi_cnt == HALF_CYC);

  // R8: done is a single-cycle strobe and coincides with select rising
  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  a_r8_done_with_cs: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $rose(cs_n_o));

  // R8: the result is held between done strobes
  a_r8_data_held: assert property (@(posedge clk) disable iff (rst)
    !done_o |=> (done_o || $stable(data_o)));

endmodule

bind adc_serial_reader adcr_checker #(.DATA_W(DATA_W), .HALF_CYC(HALF_CYC)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start_i (start_i),
  .cs_n_o  (cs_n_o),
  .sclk_o  (sclk_o),
  .data_o  (data_o),
  .done_o  (done_o)
);

// File: tb/tb_adc_serial_reader.sv
module tb_adc_serial_reader;
  localparam int DATA_W   = 8;
  localparam int HALF_CYC = 4;
  localparam int LEAD_CYC = 1;
  localparam int EXP_RISE = LEAD_CYC + DATA_W;
  localparam int EXP_CSLO = 2 * (LEAD_CYC + DATA_W) * HALF_CYC + 1;
  localparam int EXP_HI   = (LEAD_CYC + DATA_W) * HALF_CYC;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start_i = 1'b0;
  logic              sdata_i = 1'b0;
  logic              cs_n_o;
  logic              sclk_o;
  logic [DATA_W-1:0] data_o;
  logic              done_o;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  adc_serial_reader #(.DATA_W(DATA_W), .HALF_CYC(HALF_CYC), .LEAD_CYC(LEAD_CYC)) dut (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .sdata_i (sdata_i),
    .cs_n_o  (cs_n_o),
    .sclk_o  (sclk_o),
    .data_o  (data_o),
    .done_o  (done_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One read of byte val; hold keeps start_i high for the whole read (R9)
  task automatic run_frame(input int val, input bit hold);
    int  falls = 0;
    int  rises = 0;
    int  cslow = 0;
    int  hicnt = 0;
    int  guard = 0;
    bit  prev_s = 1'b0;
    bit  got = 1'b0;
    start_i = 1'b1;
    @(negedge clk);
    if (!hold) start_i = 1'b0;
    check(cs_n_o == 1'b0 && sclk_o == 1'b0, "R2 cs low after start", cs_n_o, 0);
    while (!got && guard < 1000) begin
      guard++;
      if (!cs_n_o) cslow++;
      if (sclk_o) hicnt++;
      if (sclk_o && !prev_s) rises++;
      if (!sclk_o && prev_s) begin
        falls++;
        if (falls > LEAD_CYC)
          sdata_i = 1'((val >> (DATA_W - 1 - (falls - LEAD_CYC - 1))) & 1);
        else
          sdata_i = ~sdata_i;
      end else begin
        sdata_i = ~sdata_i;
      end
      prev_s = sclk_o;
      if (done_o) begin
        got = 1'b1;
        start_i = 1'b0;
      end else begin
        @(negedge clk);
      end
    end
    check(got, "R8 done seen", int'(got), 1);
    check(int'(data_o) == val, "R5 R6 assembled byte", int'(data_o), val);
    check(cs_n_o == 1'b1 && sclk_o == 1'b0, "R8 cs high at done", cs_n_o, 1);
    check(rises == EXP_RISE, "R4 rising edges", rises, EXP_RISE);
    check(cslow == EXP_CSLO, hold ? "R9 R7 cs low cycles" : "R7 cs low cycles", cslow, EXP_CSLO);
    check(hicnt == EXP_HI, "R3 clock high cycles", hicnt, EXP_HI);
    @(negedge clk);
    check(done_o == 1'b0, "R8 done single cycle", done_o, 0);
    check(cs_n_o == 1'b1 && sclk_o == 1'b0, "R1 idle levels between reads", sclk_o, 0);
    check(int'(data_o) == val, "R8 data held", int'(data_o), val);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    n_chk++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(cs_n_o == 1'b1, "R1 reset cs_n", cs_n_o, 1);
    check(sclk_o == 1'b0, "R1 reset sclk", sclk_o, 0);
    check(done_o == 1'b0, "R1 reset done", done_o, 0);
    check(data_o == '0, "R1 reset data", int'(data_o), 0);
    for (int v = 0; v < (1 << DATA_W); v++) begin
      run_frame(v, 1'(((v >> 0) ^ (v >> 3)) & 1));
      repeat (v % 3) @(negedge clk);
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule